// File: doc/BRIEF.md
# DMA External Request Handshake Unit

This unit stands between an external peripheral and one channel of a DMA transfer engine. The peripheral asks for service by pulling an active-low request pin. The unit brings that pin into the clock domain and decides whether a request is pending. It then tells the engine, tells the peripheral that the request was taken, and strobes an active-low acknowledge line while the engine runs the chosen bus cycle of each transfer.

Per-channel control inputs choose how the unit behaves. The request can be seen as a low level or as a falling edge. The transfer can be a single transfer or a burst. The accept notification can be active-high or active-low. In a two-address transfer, the acknowledge can sit on the read cycle or on the write cycle. Combining detection style with burst mode gives two burst kinds. In a level burst, the pin is checked again after every transfer. In an edge burst, one edge starts a run that lasts until the engine reports terminal count. On a channel numbered 2 or above, the detection, polarity and acknowledge-placement controls are ignored and their zero settings apply.

Top module: `dma_xreq_handshake`

## Requirements
- R1: The request pin passes through two synchroniser flip-flops. In level mode, a low applied before clock edge k shows up as req_pending=1 after edge k+2, and not before.
- R2: In level mode (cfg_edge=0, the reset setting), req_pending equals the inverted synchronised pin. An engine take does not clear it, so a burst goes on while the pin stays low and stops once the pin is high.
- R3: In edge mode (cfg_edge=1) without burst, a high-to-low transition of the synchronised pin sets req_pending. It stays set until an engine take (eng_take=1 while pending), which clears it at that edge. A pin that stays low does not raise it again.
- R4: When a new falling edge is detected in the same cycle as a take, the new edge wins and req_pending stays 1.
- R5: In edge mode with cfg_burst=1, a take starts a burst that keeps req_pending=1 until eng_tc=1. If eng_tc and the take fall in the same cycle, terminal count wins and req_pending goes to 0.
- R6: A take while req_pending=1 makes the accept notification active for the one cycle after that edge. A take while nothing is pending produces no accept.
- R7: accept_out is the active flag XOR cfg_accept_low. With 0 it is active-high and idles low; with 1 it is active-low and idles high.
- R8: With two-address transfers (cfg_single=0), xack_n is 0 in the cycle after each cycle where eng_rd_phase=1 (cfg_ack_write=0) or where eng_wr_phase=1 (cfg_ack_write=1). Otherwise it is 1.
- R9: With single-address transfers (cfg_single=1), xack_n is 0 in the cycle after any cycle with eng_rd_phase or eng_wr_phase high, whatever cfg_ack_write is.
- R10: On a channel with CHANNEL>=2, cfg_edge, cfg_accept_low and cfg_ack_write have no effect. That channel behaves as if all three are 0.
- R11: While rst is high, req_pending=0, accept_out=0 and xack_n=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_edge | input | 1 | 0 level detection, 1 falling-edge detection |
| cfg_accept_low | input | 1 | 1 makes accept_out active-low |
| cfg_ack_write | input | 1 | Two-address: 0 acknowledge in read cycle, 1 in write cycle |
| cfg_burst | input | 1 | 1 selects burst transfer |
| cfg_single | input | 1 | 1 selects single-address transfer |
| xreq_n | input | 1 | Asynchronous active-low request from the peripheral |
| eng_take | input | 1 | Engine takes the pending request this cycle |
| eng_tc | input | 1 | Engine reached terminal count |
| eng_rd_phase | input | 1 | Engine is in the data read cycle |
| eng_wr_phase | input | 1 | Engine is in the data write cycle |
| req_pending | output | 1 | Request pending to the engine |
| accept_out | output | 1 | Accept notification to the peripheral |
| xack_n | output | 1 | Active-low acknowledge strobe |

## Verification
Two pairs of events can meet in one cycle: a freshly detected falling edge with an engine take, and a take with terminal count in an edge burst. For the first pair, the bench lowers the pin so that the detected edge arrives exactly at the edge where a take is driven, and expects the request to stay pending. For the second pair, it drives the take and eng_tc together on a new burst and expects pending to drop. Acknowledge placement and accept polarity are then driven with seeded random settings and strobes, and each cycle is compared against a bench model. A second instance, built for a high-numbered channel, shows that the ignored controls really have no effect.

// File: rtl/dma_xreq_pkg.sv
package dma_xreq_pkg;
  // Controls that only low-numbered channels honour.
  typedef struct packed {
    logic fall_det;
    logic acc_low;
    logic ack_on_wr;
  } xreq_ctl_t;

  localparam int unsigned HONOUR_CHANNELS = 2;
  localparam xreq_ctl_t   CTL_NEUTRAL     = '0;
endpackage

// File: rtl/xreq_sync.sv
module xreq_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{RESET_VAL}};
    else     sh <= {sh[STAGES-2:0], din};
  end

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/xreq_detect.sv
module xreq_detect (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,      // synchronised, active low
  input  logic fall_mode,
  input  logic burst_mode,
  input  logic take_ok,
  input  logic tc,
  output logic pending
);
  logic prev_q, flag_q, burst_q, pend_q;
  logic fall, flag_d, burst_d, pend_d;

  assign fall    = prev_q & ~pin_s;
  // new edge wins over a take in the same cycle
  assign flag_d  = fall_mode & (fall | (flag_q & ~take_ok));
  // terminal count wins over a take in the same cycle
  assign burst_d = fall_mode & burst_mode & ~tc & (burst_q | take_ok);
  assign pend_d  = fall_mode ? (flag_d | burst_d) : ~pin_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b1;
      flag_q  <= 1'b0;
      burst_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      prev_q  <= pin_s;
      flag_q  <= flag_d;
      burst_q <= burst_d;
      pend_q  <= pend_d;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/xreq_accept.sv
module xreq_accept (
  input  logic clk,
  input  logic rst,
  input  logic take_ok,
  input  logic acc_low,
  output logic acc_out
);
  logic acc_q;

  always_ff @(posedge clk) begin
    if (rst) acc_q <= 1'b0;
    else     acc_q <= take_ok ^ acc_low;
  end

  assign acc_out = acc_q;
endmodule

// File: rtl/xack_gen.sv
module xack_gen (
  input  logic clk,
  input  logic rst,
  input  logic rd_phase,
  input  logic wr_phase,
  input  logic single,
  input  logic on_wr,
  output logic ack_n
);
  logic ack_q, hit;

  assign hit = single ? (rd_phase | wr_phase)
                      : (on_wr ? wr_phase : rd_phase);

  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b1;
    else     ack_q <= ~hit;
  end

  assign ack_n = ack_q;
endmodule

// File: rtl/dma_xreq_handshake.sv
module dma_xreq_handshake
  import dma_xreq_pkg::*;
#(
  parameter int unsigned CHANNEL     = 0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_edge,
  input  logic cfg_accept_low,
  input  logic cfg_ack_write,
  input  logic cfg_burst,
  input  logic cfg_single,
  input  logic xreq_n,
  input  logic eng_take,
  input  logic eng_tc,
  input  logic eng_rd_phase,
  input  logic eng_wr_phase,
  output logic req_pending,
  output logic accept_out,
  output logic xack_n
);
  localparam xreq_ctl_t CTL_MASK = (CHANNEL < HONOUR_CHANNELS) ? '1 : CTL_NEUTRAL;

  xreq_ctl_t ctl_raw, ctl_eff;
  logic      edge_eff, acc_low_eff, ack_wr_eff;
  logic      pin_s, take_ok;

  assign ctl_raw     = '{fall_det: cfg_edge, acc_low: cfg_accept_low, ack_on_wr: cfg_ack_write};
  assign ctl_eff     = ctl_raw & CTL_MASK;
  assign edge_eff    = ctl_eff.fall_det;
  assign acc_low_eff = ctl_eff.acc_low;
  assign ack_wr_eff  = ctl_eff.ack_on_wr;

  assign take_ok = eng_take & req_pending;

  xreq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk (clk), .rst (rst), .din (xreq_n), .dout (pin_s)
  );

  xreq_detect u_detect (
    .clk        (clk),
    .rst        (rst),
    .pin_s      (pin_s),
    .fall_mode  (edge_eff),
    .burst_mode (cfg_burst),
    .take_ok    (take_ok),
    .tc         (eng_tc),
    .pending    (req_pending)
  );

  xreq_accept u_accept (
    .clk (clk), .rst (rst), .take_ok (take_ok),
    .acc_low (acc_low_eff), .acc_out (accept_out)
  );

  xack_gen u_ack (
    .clk      (clk),
    .rst      (rst),
    .rd_phase (eng_rd_phase),
    .wr_phase (eng_wr_phase),
    .single   (cfg_single),
    .on_wr    (ack_wr_eff),
    .ack_n    (xack_n)
  );
endmodule

// File: rtl/dma_xreq_checker.sv
module dma_xreq_checker (
  input logic clk,
  input logic rst,
  input logic xreq_n,
  input logic eng_take,
  input logic eng_rd_phase,
  input logic eng_wr_phase,
  input logic cfg_burst,
  input logic cfg_single,
  input logic edge_eff,
  input logic acc_low_eff,
  input logic req_pending,
  input logic accept_out,
  input logic xack_n
);
  logic [1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst)           cyc <= '0;
    else if (cyc != 3) cyc <= cyc + 2'd1;
  end

  // R2 with R1 latency: level mode tracks the pin three edges back
  assert_level_track_R2: assert property (@(posedge clk) disable iff (rst)
    (cyc == 3 && !$past(edge_eff)) |-> (req_pending == !$past(xreq_n, 3)));

  // R3: a non-burst edge request only drops after a take
  assert_edge_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 2 && edge_eff && $past(edge_eff) && $past(edge_eff, 2)
     && !$past(cfg_burst) && !$past(cfg_burst, 2)
     && $past(req_pending) && !$past(eng_take)) |-> req_pending);

  // R6: an active accept always follows a take of a pending request
  assert_accept_cause_R6: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 1 && (accept_out != $past(acc_low_eff))) |-> $past(eng_take && req_pending));

  // R7: with no take the accept output rests at its idle level
  assert_accept_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 1 && !$past(eng_take)) |-> (accept_out == $past(acc_low_eff)));

  // R8: the acknowledge only appears after a bus phase strobe
  assert_ack_phase_R8: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 1 && !xack_n) |-> $past(eng_rd_phase || eng_wr_phase));

  // R9: single-address transfers acknowledge every phase
  assert_single_ack_R9: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 1 && $past(cfg_single && (eng_rd_phase || eng_wr_phase))) |-> !xack_n);

  // R11: reset values
  always @(negedge clk) begin
    if (rst && $past(rst)) begin
      assert_reset_vals_R11: assert (!req_pending && !accept_out && xack_n);
    end
  end
endmodule

bind dma_xreq_handshake dma_xreq_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .xreq_n       (xreq_n),
  .eng_take     (eng_take),
  .eng_rd_phase (eng_rd_phase),
  .eng_wr_phase (eng_wr_phase),
  .cfg_burst    (cfg_burst),
  .cfg_single   (cfg_single),
  .edge_eff     (edge_eff),
  .acc_low_eff  (acc_low_eff),
  .req_pending  (req_pending),
  .accept_out   (accept_out),
  .xack_n       (xack_n)
);

// File: tb/dma_xreq_handshake_test.sv
`timescale 1ns/1ps
module dma_xreq_handshake_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, cfg_edge, cfg_accept_low, cfg_ack_write, cfg_burst, cfg_single;
  logic xreq_n, eng_take, eng_tc, eng_rd_phase, eng_wr_phase;
  logic req_pending, accept_out, xack_n;
  logic hi_pending, hi_accept, hi_ack_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dma_xreq_handshake #(.CHANNEL(0)) uut (
    .clk, .rst, .cfg_edge, .cfg_accept_low, .cfg_ack_write, .cfg_burst, .cfg_single,
    .xreq_n, .eng_take, .eng_tc, .eng_rd_phase, .eng_wr_phase,
    .req_pending, .accept_out, .xack_n
  );

  dma_xreq_handshake #(.CHANNEL(2)) uut_hi (
    .clk, .rst, .cfg_edge, .cfg_accept_low, .cfg_ack_write, .cfg_burst, .cfg_single,
    .xreq_n, .eng_take, .eng_tc, .eng_rd_phase, .eng_wr_phase,
    .req_pending (hi_pending), .accept_out (hi_accept), .xack_n (hi_ack_n)
  );

  function automatic logic exp_ack_n(logic rd, logic wr, logic on_wr, logic single);
    return !(single ? (rd | wr) : (on_wr ? wr : rd));
  endfunction

  function automatic logic exp_accept(logic took, logic low);
    return took ^ low;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic pulse_take();
    eng_take = 1'b1; tick(1); eng_take = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; cfg_edge = 0; cfg_accept_low = 0; cfg_ack_write = 0; cfg_burst = 0;
    cfg_single = 0; xreq_n = 1; eng_take = 0; eng_tc = 0;
    eng_rd_phase = 0; eng_wr_phase = 0;
    tick(3);
    check("R11 pending", req_pending, 1'b0);
    check("R11 accept", accept_out, 1'b0);
    check("R11 ack", xack_n, 1'b1);
    rst = 0;

    // R1 / R2 level detection latency
    xreq_n = 0;
    tick(2); check("R1 not yet", req_pending, 1'b0);
    tick(1); check("R1 pending", req_pending, 1'b1);
    xreq_n = 1;
    tick(3); check("R2 released", req_pending, 1'b0);

    // R2 level burst continues while pin low
    cfg_burst = 1; xreq_n = 0; tick(3);
    pulse_take();
    check("R2 burst continues", req_pending, 1'b1);
    check("R6 accept pulse", accept_out, 1'b1);
    tick(1); check("R6 single cycle", accept_out, 1'b0);
    xreq_n = 1; tick(3);
    check("R2 burst ends", req_pending, 1'b0);
    cfg_burst = 0;

    // R3 edge mode
    cfg_edge = 1; tick(2);
    check("R3 idle", req_pending, 1'b0);
    xreq_n = 0; tick(3);
    check("R3 edge seen", req_pending, 1'b1);
    tick(5);
    check("R3 held", req_pending, 1'b1);
    check("R10 hi level", hi_pending, 1'b1);
    pulse_take();
    check("R3 cleared by take", req_pending, 1'b0);
    check("R6 accept edge", accept_out, 1'b1);
    tick(4);
    check("R3 steady low", req_pending, 1'b0);
    check("R10 hi still level", hi_pending, 1'b1);
    pulse_take();
    check("R6 take ignored", accept_out, 1'b0);
    check("R6 take ignored pending", req_pending, 1'b0);

    // R4 edge and take collide
    xreq_n = 1; tick(3);
    xreq_n = 0; tick(3);
    check("R4 first edge", req_pending, 1'b1);
    xreq_n = 1; tick(3);
    xreq_n = 0; tick(2);
    pulse_take();
    check("R4 new edge wins", req_pending, 1'b1);
    check("R4 accept", accept_out, 1'b1);
    pulse_take();
    check("R4 second take clears", req_pending, 1'b0);

    // R5 edge burst
    cfg_burst = 1;
    xreq_n = 1; tick(3); xreq_n = 0; tick(3);
    pulse_take();
    check("R5 burst started", req_pending, 1'b1);
    xreq_n = 1; tick(5);
    check("R5 burst runs", req_pending, 1'b1);
    eng_tc = 1; tick(1); eng_tc = 0;
    check("R5 tc ends", req_pending, 1'b0);
    xreq_n = 0; tick(3);
    check("R5 new edge", req_pending, 1'b1);
    eng_take = 1; eng_tc = 1; tick(1); eng_take = 0; eng_tc = 0;
    check("R5 tc wins", req_pending, 1'b0);
    cfg_burst = 0; cfg_edge = 0;
    tick(3);

    // R7 polarity
    cfg_accept_low = 1; tick(1);
    check("R7 idle high", accept_out, 1'b1);
    check("R10 hi polarity", hi_accept, 1'b0);
    pulse_take();
    check("R7 active low", accept_out, 1'b0);
    check("R10 hi active", hi_accept, 1'b1);
    tick(1);
    check("R7 back idle", accept_out, 1'b1);
    cfg_accept_low = 0;

    // R6 / R7 random accept, level mode, pin low
    for (int i = 0; i < 200; i++) begin
      logic t, p;
      t = 1'($urandom % 2); p = 1'($urandom % 2);
      eng_take = t; cfg_accept_low = p;
      tick(1);
      check("R7 random accept", accept_out, exp_accept(t, p));
      check("R10 random accept", hi_accept, exp_accept(t, 1'b0));
    end
    eng_take = 0; cfg_accept_low = 0;

    // R8 / R9 random acknowledge placement
    for (int i = 0; i < 300; i++) begin
      logic rd, wr, aw, sg;
      rd = 1'($urandom % 2); wr = 1'($urandom % 2);
      aw = 1'($urandom % 2); sg = 1'($urandom % 4 == 0);
      eng_rd_phase = rd; eng_wr_phase = wr; cfg_ack_write = aw; cfg_single = sg;
      tick(1);
      check(sg ? "R9 single ack" : "R8 dual ack", xack_n, exp_ack_n(rd, wr, aw, sg));
      check("R10 ack", hi_ack_n, exp_ack_n(rd, wr, 1'b0, sg));
    end
    eng_rd_phase = 0; eng_wr_phase = 0;
    tick(1);
    check("R8 idle", xack_n, 1'b1);

    finish_run();
  end
endmodule